// File: doc/BRIEF.md
# Alpha Modifier and Two-Source Pixel Blender

This block merges two pixels into one. Each cycle it can accept a foreground and a background pixel, both already widened to 8-bit ARGB. It first adjusts each alpha according to that input's own alpha mode and constant. It then either composites the foreground over the background, or passes the foreground colour straight through with only its alpha adjusted, which serves plain copies.

The datapath has three register stages and one valid/ready handshake on the input pair and another on the output. The pipeline stalls as a whole when the output is held, so no pixel is lost or repeated and order is kept. The mode and constant inputs are treated as static while pixels are in flight. Pixel layout on every data port is alpha in bits [31:24], red in [23:16], green in [15:8] and blue in [7:0].

Top module: `pix_blend_core`

## Requirements
- R1: During and after synchronous reset `out_valid` is low, and `in_ready` is high whenever `out_valid` is low.
- R2: Alpha mode code 0 keeps the pixel's own alpha. The unused code 3 behaves like code 0.
- R3: Alpha mode code 1 replaces the pixel alpha with that input's constant.
- R4: Alpha mode code 2 replaces the alpha a with the rounded product (a*k+127)/255 in integer division, where k is that input's constant.
- R5: Foreground and background each use their own mode and constant, independently of each other.
- R6: With `cfg_blend_en` low, the output is the adjusted foreground alpha with the foreground RGB unchanged, and the background pixel has no effect.
- R7: With `cfg_blend_en` high, the output alpha is af + ab - floor(af*ab/255), using the adjusted alphas.
- R8: With `cfg_blend_en` high, each colour channel is floor((Cf*af + Cb*abw)/aout), where abw = floor(ab*(255-af)/255).
- R9: With `cfg_blend_en` high and an output alpha of 0, all three colour channels are 0.
- R10: A pixel accepted at a rising edge while the pipeline is empty and `out_ready` is high appears with `out_valid` high after the second following rising edge. No more than three pixels are ever in flight.
- R11: While `out_valid` is high and `out_ready` is low, `out_pix` holds its value and `in_ready` is low. Every accepted pixel leaves exactly once, in order.
- R12: With `out_ready` held high, `in_ready` stays high and N back-to-back pixels all complete within N+3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_blend_en | input | 1 | 1 = composite the two inputs, 0 = pass the foreground through |
| cfg_fg_amode | input | 2 | Foreground alpha mode: 0 keep, 1 replace, 2 scale, 3 keep |
| cfg_fg_aconst | input | 8 | Foreground alpha constant |
| cfg_bg_amode | input | 2 | Background alpha mode, same codes as the foreground |
| cfg_bg_aconst | input | 8 | Background alpha constant |
| in_valid | input | 1 | Input pixel pair is valid |
| in_ready | output | 1 | Block can take the input pair |
| in_fg | input | 32 | Foreground ARGB pixel |
| in_bg | input | 32 | Background ARGB pixel |
| out_valid | output | 1 | Output pixel is valid |
| out_ready | input | 1 | Consumer takes the output pixel |
| out_pix | output | 32 | Result ARGB pixel |

## Verification
The bench sweeps every 8-bit foreground alpha through each alpha mode, using several scale constants including 0 and 255. This catches a scaler that truncates instead of rounding, or one that reaches 254 instead of 255 at full scale. A 16-by-16 grid of foreground and background alphas that includes both extremes is blended under random backpressure. That grid exposes a wrong weight on the background term, a missing divide-by-zero guard that would emit garbage colour at zero alpha, and a stall path that drops or repeats pixels. Single-pixel and full-rate runs catch an extra or missing register stage and a pipeline that inserts bubbles.

// File: rtl/pix_blend_pkg.sv
package pix_blend_pkg;

  typedef enum logic [1:0] {
    AM_KEEP  = 2'd0,
    AM_FIXED = 2'd1,
    AM_SCALE = 2'd2,
    AM_RSVD  = 2'd3
  } amode_e;

  localparam int unsigned NCH    = 3;
  localparam int unsigned LAT    = 3;

endpackage

// File: rtl/pb_alpha_mod.sv
module pb_alpha_mod
  import pix_blend_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic [1:0]    mode,
  input  logic [CW-1:0] a_in,
  input  logic [CW-1:0] k,
  output logic [CW-1:0] a_out
);
  localparam int unsigned W2   = 2 * CW;
  localparam int unsigned MAXV = (1 << CW) - 1;
  localparam int unsigned HALF = MAXV >> 1;

  logic [W2-1:0] prod;

  always_comb begin
    prod = W2'(a_in) * W2'(k) + W2'(HALF);
    unique case (amode_e'(mode))
      AM_FIXED: a_out = k;
      AM_SCALE: a_out = CW'(prod / W2'(MAXV));
      default:  a_out = a_in;
    endcase
  end
endmodule

// File: rtl/pb_blend_terms.sv
module pb_blend_terms
  import pix_blend_pkg::*;
#(
  parameter int unsigned CW   = 8,
  parameter int unsigned NUMW = 2 * CW + 1
) (
  input  logic [CW-1:0]          af,
  input  logic [CW-1:0]          ab,
  input  logic [NCH*CW-1:0]      f_rgb,
  input  logic [NCH*CW-1:0]      b_rgb,
  output logic [CW-1:0]          a_res,
  output logic [NCH*NUMW-1:0]    num
);
  localparam int unsigned W2   = 2 * CW;
  localparam int unsigned MAXV = (1 << CW) - 1;

  logic [W2-1:0] p_fb;
  logic [W2-1:0] p_bw;
  logic [CW-1:0] ab_w;

  always_comb begin
    p_fb  = W2'(af) * W2'(ab);
    p_bw  = W2'(ab) * W2'(CW'(MAXV) - af);
    ab_w  = CW'(p_bw / W2'(MAXV));
    a_res = CW'(W2'(af) + W2'(ab) - p_fb / W2'(MAXV));
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign num[c*NUMW +: NUMW] = NUMW'(f_rgb[c*CW +: CW]) * NUMW'(af)
                               + NUMW'(b_rgb[c*CW +: CW]) * NUMW'(ab_w);
  end
endmodule

// File: rtl/pb_chan_div.sv
module pb_chan_div #(
  parameter int unsigned CW   = 8,
  parameter int unsigned NUMW = 2 * CW + 1
) (
  input  logic [NUMW-1:0] num,
  input  logic [CW-1:0]   den,
  output logic [CW-1:0]   q
);
  always_comb begin
    if (den == '0) q = '0;
    else           q = CW'(num / NUMW'(den));
  end
endmodule

// File: rtl/pix_blend_core.sv
module pix_blend_core
  import pix_blend_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_blend_en,
  input  logic [1:0]      cfg_fg_amode,
  input  logic [CW-1:0]   cfg_fg_aconst,
  input  logic [1:0]      cfg_bg_amode,
  input  logic [CW-1:0]   cfg_bg_aconst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [4*CW-1:0] in_fg,
  input  logic [4*CW-1:0] in_bg,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [4*CW-1:0] out_pix
);
  localparam int unsigned PW   = 4 * CW;
  localparam int unsigned CWR  = NCH * CW;
  localparam int unsigned NUMW = 2 * CW + 1;

  logic advance;
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  // stage 1: alpha adjustment
  logic [CW-1:0]  af_c, ab_c;
  logic           s1_v;
  logic [CW-1:0]  s1_af, s1_ab;
  logic [CWR-1:0] s1_frgb, s1_brgb;

  pb_alpha_mod #(.CW(CW)) u_amod_fg (
    .mode(cfg_fg_amode), .a_in(in_fg[PW-1 -: CW]), .k(cfg_fg_aconst), .a_out(af_c)
  );
  pb_alpha_mod #(.CW(CW)) u_amod_bg (
    .mode(cfg_bg_amode), .a_in(in_bg[PW-1 -: CW]), .k(cfg_bg_aconst), .a_out(ab_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
    end else if (advance) begin
      s1_v <= in_valid;
    end
    if (advance) begin
      s1_af   <= af_c;
      s1_ab   <= ab_c;
      s1_frgb <= in_fg[CWR-1:0];
      s1_brgb <= in_bg[CWR-1:0];
    end
  end

  // stage 2: alpha combine and weighted sums
  logic [CW-1:0]       a_res_c;
  logic [NCH*NUMW-1:0] num_c;
  logic                s2_v, s2_blend;
  logic [CW-1:0]       s2_a;
  logic [NCH*NUMW-1:0] s2_num;
  logic [CWR-1:0]      s2_frgb;

  pb_blend_terms #(.CW(CW), .NUMW(NUMW)) u_terms (
    .af(s1_af), .ab(s1_ab), .f_rgb(s1_frgb), .b_rgb(s1_brgb),
    .a_res(a_res_c), .num(num_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v <= 1'b0;
    end else if (advance) begin
      s2_v <= s1_v;
    end
    if (advance) begin
      s2_blend <= cfg_blend_en;
      s2_a     <= cfg_blend_en ? a_res_c : s1_af;
      s2_num   <= num_c;
      s2_frgb  <= s1_frgb;
    end
  end

  // stage 3: normalise and output register
  logic [CWR-1:0] div_c;

  for (genvar c = 0; c < NCH; c++) begin : g_div
    pb_chan_div #(.CW(CW), .NUMW(NUMW)) u_div (
      .num(s2_num[c*NUMW +: NUMW]), .den(s2_a), .q(div_c[c*CW +: CW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (advance) begin
      out_valid <= s2_v;
    end
    if (advance) begin
      out_pix <= {s2_a, (s2_blend ? div_c : s2_frgb)};
    end
  end
endmodule

// File: rtl/pb_blend_chk.sv
module pb_blend_chk #(
  parameter int unsigned CW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_blend_en,
  input logic [1:0]      cfg_fg_amode,
  input logic [CW-1:0]   cfg_fg_aconst,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [4*CW-1:0] out_pix
);
  logic [2:0] occ;

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else occ <= occ + 3'((in_valid && in_ready) ? 1 : 0)
                    - 3'((out_valid && out_ready) ? 1 : 0);
  end

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> !out_valid);

  p_ready_empty_r1: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  p_fixed_alpha_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !cfg_blend_en && cfg_fg_amode == 2'd1)
      |-> out_pix[4*CW-1 -: CW] == cfg_fg_aconst);

  p_zero_alpha_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cfg_blend_en && out_pix[4*CW-1 -: CW] == '0)
      |-> out_pix[3*CW-1:0] == '0);

  p_inflight_r10: assert property (@(posedge clk) disable iff (rst)
    occ <= 3'd3);

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

  p_stall_r11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind pix_blend_core pb_blend_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .cfg_blend_en(cfg_blend_en),
  .cfg_fg_amode(cfg_fg_amode), .cfg_fg_aconst(cfg_fg_aconst),
  .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
);

// File: tb/sim_pix_blend_core.sv
module sim_pix_blend_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        blend = 1'b0;
  logic [1:0]  fg_mode = 2'd0, bg_mode = 2'd0;
  logic [7:0]  fg_k = 8'd0, bg_k = 8'd0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_fg = '0, in_bg = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_pix;

  int checks = 0;
  int errors = 0;
  logic [31:0] expq[$];
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_blend_core #(.CW(8)) u0 (
    .clk(clk), .rst(rst), .cfg_blend_en(blend),
    .cfg_fg_amode(fg_mode), .cfg_fg_aconst(fg_k),
    .cfg_bg_amode(bg_mode), .cfg_bg_aconst(bg_k),
    .in_valid(in_valid), .in_ready(in_ready), .in_fg(in_fg), .in_bg(in_bg),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic int amod(input int a, input logic [1:0] m, input int k);
    if (m == 2'd1) return k;
    if (m == 2'd2) return (a * k + 127) / 255;
    return a;
  endfunction

  function automatic logic [31:0] model(input logic [31:0] f, input logic [31:0] b);
    int af, ab, abw, ao, cf, cb, cc;
    logic [31:0] r;
    af = amod(int'(f[31:24]), fg_mode, int'(fg_k));
    ab = amod(int'(b[31:24]), bg_mode, int'(bg_k));
    if (!blend) return {af[7:0], f[23:0]};
    abw = ab * (255 - af) / 255;
    ao  = af + ab - (af * ab) / 255;
    r = '0;
    r[31:24] = ao[7:0];
    for (int c = 0; c < 3; c++) begin
      cf = int'(f[8*c +: 8]);
      cb = int'(b[8*c +: 8]);
      cc = (ao == 0) ? 0 : (cf * af + cb * abw) / ao;
      r[8*c +: 8] = cc[7:0];
    end
    return r;
  endfunction

  function automatic logic [31:0] gen_fg(input int ph, input int i);
    int a;
    a = (ph >= 3) ? ((i / 16) % 16) * 17 : i % 256;
    return {a[7:0], 8'((i * 29 + 3)), 8'((i * 53 + 11)), 8'((255 - i * 7))};
  endfunction

  function automatic logic [31:0] gen_bg(input int ph, input int i);
    int a;
    a = (ph >= 3) ? (i % 16) * 17 : (i * 91) % 256;
    return {a[7:0], 8'((i * 71 + 40)), 8'((i * 17 + 200)), 8'((i * 113 + 9))};
  endfunction

  task automatic stream(input int ph, input int n, input bit bp, input string tag, output int iters);
    int sent = 0;
    bit hold_v = 0;
    logic [31:0] hold_pix = '0;
    logic [31:0] e;
    iters = 0;
    while (sent < n || expq.size() > 0) begin
      @(negedge clk);
      iters++;
      if (hold_v) chk(out_valid === 1'b1 && out_pix === hold_pix, "R11 hold", out_pix, hold_pix);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = bp ? (lfsr[0] | lfsr[3]) : 1'b1;
      if (sent < n) begin
        in_fg = gen_fg(ph, sent);
        in_bg = gen_bg(ph, sent);
        in_valid = 1'b1;
      end else in_valid = 1'b0;
      #1;
      hold_v = out_valid && !out_ready;
      hold_pix = out_pix;
      if (hold_v) chk(in_ready == 1'b0, "R11 stall", {31'd0, in_ready}, 32'd0);
      if (out_valid && out_ready) begin
        if (expq.size() == 0) chk(1'b0, "R11 extra output", out_pix, 32'd0);
        else begin
          e = expq.pop_front();
          chk(out_pix === e, tag, out_pix, e);
        end
      end
      if (in_valid && in_ready) begin
        expq.push_back(model(in_fg, in_bg));
        sent++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int it;
    int kv[5];
    kv = '{0, 1, 77, 128, 255};
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R1 reset valid", {31'd0, out_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R1 idle", {30'd0, out_valid, in_ready}, 32'd1);

    // R10: single pixel latency
    blend = 1'b0; fg_mode = 2'd0;
    in_fg = 32'h80112233; in_bg = 32'h0; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    chk(out_valid === 1'b0, "R10 edge1", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    chk(out_valid === 1'b0, "R10 edge2", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    chk(out_valid === 1'b1 && out_pix === 32'h80112233, "R10 edge3", out_pix, 32'h80112233);
    @(negedge clk);

    // R2/R6 pass-through keep, full rate (R12)
    stream(0, 256, 1'b0, "R2/R6 keep", it);
    chk(it == 259, "R12 throughput", it, 259);
    fg_mode = 2'd3;
    stream(0, 64, 1'b1, "R2 code3", it);
    fg_mode = 2'd1; fg_k = 8'h5A;
    stream(1, 64, 1'b1, "R3 replace", it);
    fg_mode = 2'd2;
    for (int j = 0; j < 5; j++) begin
      fg_k = kv[j][7:0];
      stream(2, 256, j[0], "R4 scale", it);
    end

    // blending
    blend = 1'b1; fg_mode = 2'd0; bg_mode = 2'd0;
    stream(3, 256, 1'b1, "R7/R8 blend", it);
    fg_mode = 2'd1; fg_k = 8'd0; bg_mode = 2'd1; bg_k = 8'd0;
    stream(4, 32, 1'b0, "R9 zero", it);
    fg_mode = 2'd2; fg_k = 8'd200; bg_mode = 2'd2; bg_k = 8'd100;
    stream(5, 256, 1'b1, "R5 mixed", it);
    fg_mode = 2'd0; bg_mode = 2'd1; bg_k = 8'd160;
    stream(5, 256, 1'b0, "R5 split", it);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule